// File: doc/BRIEF.md
# USB Endpoint Interrupt Controller

This block sits between the packet engine of a USB device core and the interrupt controller of the processor. It works on physical endpoints. Even indices are OUT endpoints and odd indices are IN endpoints, so a logical endpoint `k` owns physical endpoints `2k` (OUT) and `2k+1` (IN).

Each physical endpoint has one status bit. A qualified transfer event sets that bit:
- An OUT endpoint counts a packet received without error.
- An IN endpoint counts a packet sent successfully.
- An IN endpoint also counts a NAK it has sent, but only if NAK reporting is switched on for that endpoint.
- An endpoint marked isochronous never sets its bit.

Software reads the status bits and clears them one by one. It enables endpoints for interrupt handling and gives each endpoint a priority bit. The priority bit sends the endpoint to either the fast or the slow device interrupt line.

Register accesses use a simple word interface. A write takes effect in the same cycle as `wr_en_i`. Reads are combinational from `rd_addr_i`. Writes to an address outside the register map have no effect, and reads from such an address return zero. The data word is one bit per physical endpoint, with bit `p` belonging to physical endpoint `p`.

Top module: `ep_irq_ctrl`

## Requirements
- R1: A pulse on `evt_rx_ok_i[p]` sets status bit `p` on the next clock edge when `p` is even (OUT) and `ep_iso_i[p]` is 0. On an odd `p` (IN), `evt_rx_ok_i[p]` has no effect.
- R2: A pulse on `evt_tx_ok_i[p]` sets status bit `p` on the next clock edge when `p` is odd (IN) and `ep_iso_i[p]` is 0. On an even `p` (OUT), `evt_tx_ok_i[p]` has no effect.
- R3: A pulse on `evt_nak_i[p]` sets status bit `p` only when `p` is odd, `ep_iso_i[p]` is 0, and bit `p` of the NAK-report register (address 5) is 1. In every other case the pulse has no effect.
- R4: When `ep_iso_i[p]` is 1, no event input sets status bit `p`.
- R5: Writing to the clear register (address 2) clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R6: Writing to the set register (address 3) sets each status bit whose data bit is 1. Reads of address 2, address 3, address 6 and address 7 return 0.
- R7: If a qualified event and a clear write hit the same status bit in the same cycle, the bit is set after the clock edge.
- R8: After reset the registers hold these values:
  - status (address 0) reads 0;
  - enable (address 1) reads with only bits 0 and 1 set;
  - priority (address 4) reads 0;
  - NAK-report (address 5) reads 0;
  - both interrupt outputs are 0.
- R9: `irq_slow_o` is registered. In each cycle it equals the OR of (status AND enable AND NOT priority) as it stood in the previous cycle.
- R10: `irq_fast_o` is registered. In each cycle it equals the OR of (status AND enable AND priority) as it stood in the previous cycle.
- R11: A disabled endpoint still has its status bit set by qualified events, and that bit can be read back. The bit drives neither interrupt output until the endpoint is enabled.
- R12: The enable, priority and NAK-report registers (addresses 1, 4 and 5) read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | NUM_EP | Register write data, one bit per physical endpoint |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | NUM_EP | Register read data (combinational) |
| ep_iso_i | input | NUM_EP | Per-endpoint isochronous type flag |
| evt_rx_ok_i | input | NUM_EP | Pulse: error-free packet received |
| evt_tx_ok_i | input | NUM_EP | Pulse: packet transmitted successfully |
| evt_nak_i | input | NUM_EP | Pulse: NAK handshake sent |
| irq_fast_o | output | 1 | Fast device interrupt request |
| irq_slow_o | output | 1 | Slow device interrupt request |

## Verification
The bench builds the block with `NUM_LOG_EP = 2`. That gives four physical endpoints: two OUT and two IN, with both control endpoints among them. With only four endpoints, every combination of the following can be swept in full:
- endpoint direction, isochronous flag, NAK reporting and the three event kinds;
- enable, priority and status patterns, in all 4096 combinations, with both interrupt lines compared against an arithmetic model.

Clear and set patterns are also swept in full. The event-against-clear collision and the routing of a disabled endpoint each get a directed case.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_STATUS = 3'd0,
    RA_ENABLE = 3'd1,
    RA_CLEAR  = 3'd2,
    RA_SET    = 3'd3,
    RA_PRIO   = 3'd4,
    RA_NAKREP = 3'd5
  } reg_addr_e;

  // Decide whether the events seen on one physical endpoint count.
  function automatic logic ep_event_hit(
    input logic is_in,
    input logic iso,
    input logic rx_ok,
    input logic tx_ok,
    input logic nak,
    input logic nak_rep
  );
    logic dir_hit;
    dir_hit = is_in ? (tx_ok | (nak & nak_rep)) : rx_ok;
    return dir_hit & ~iso;
  endfunction

  // OR-reduce the status bits that are enabled and routed to the chosen line.
  function automatic logic line_request(
    input logic [63:0] sts,
    input logic [63:0] en,
    input logic [63:0] prio,
    input logic        want_fast
  );
    logic [63:0] sel;
    sel = want_fast ? prio : ~prio;
    return |(sts & en & sel);
  endfunction

endpackage

// File: rtl/ep_irq_regs.sv
module ep_irq_regs
  import ep_irq_pkg::*;
#(
  parameter int NUM_EP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [NUM_EP-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  input  logic [NUM_EP-1:0] sts_i,
  output logic [NUM_EP-1:0] rd_data_o,
  output logic [NUM_EP-1:0] en_o,
  output logic [NUM_EP-1:0] prio_o,
  output logic [NUM_EP-1:0] nak_rep_o,
  output logic [NUM_EP-1:0] clr_mask_o,
  output logic [NUM_EP-1:0] set_mask_o
);

  // Only the two control endpoints are enabled after reset.
  localparam logic [NUM_EP-1:0] EN_RST = NUM_EP'(2'b11);

  reg_addr_e wa;
  reg_addr_e ra;
  assign wa = reg_addr_e'(wr_addr_i);
  assign ra = reg_addr_e'(rd_addr_i);

  logic wr_enable, wr_prio, wr_nakrep;
  assign wr_enable = wr_en_i && (wa == RA_ENABLE);
  assign wr_prio   = wr_en_i && (wa == RA_PRIO);
  assign wr_nakrep = wr_en_i && (wa == RA_NAKREP);

  assign clr_mask_o = (wr_en_i && (wa == RA_CLEAR)) ? wr_data_i : '0;
  assign set_mask_o = (wr_en_i && (wa == RA_SET))   ? wr_data_i : '0;

  logic [NUM_EP-1:0] en_q, prio_q, nak_rep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= EN_RST;
      prio_q    <= '0;
      nak_rep_q <= '0;
    end else begin
      if (wr_enable) en_q      <= wr_data_i;
      if (wr_prio)   prio_q    <= wr_data_i;
      if (wr_nakrep) nak_rep_q <= wr_data_i;
    end
  end

  assign en_o      = en_q;
  assign prio_o    = prio_q;
  assign nak_rep_o = nak_rep_q;

  always_comb begin
    case (ra)
      RA_STATUS: rd_data_o = sts_i;
      RA_ENABLE: rd_data_o = en_q;
      RA_PRIO:   rd_data_o = prio_q;
      RA_NAKREP: rd_data_o = nak_rep_q;
      default:   rd_data_o = '0;
    endcase
  end

  // R12: a write to the enable register shows up in the next cycle.
  p_enable_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> (en_q == $past(wr_data_i)));

  // R6: the clear and set strobes never fire in the same cycle.
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask_o != '0) |-> (set_mask_o == '0)));

endmodule

// File: rtl/ep_irq_src.sv
module ep_irq_src
  import ep_irq_pkg::*;
#(
  parameter int NUM_EP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_iso_i,
  input  logic [NUM_EP-1:0] evt_rx_ok_i,
  input  logic [NUM_EP-1:0] evt_tx_ok_i,
  input  logic [NUM_EP-1:0] evt_nak_i,
  input  logic [NUM_EP-1:0] nak_rep_i,
  output logic [NUM_EP-1:0] hit_o
);

  // Odd physical endpoints are IN, even ones are OUT.
  for (genvar p = 0; p < NUM_EP; p++) begin : g_ep
    localparam logic IS_IN = (p % 2) == 1;
    assign hit_o[p] = ep_event_hit(IS_IN, ep_iso_i[p], evt_rx_ok_i[p],
                                   evt_tx_ok_i[p], evt_nak_i[p], nak_rep_i[p]);
  end

  // R4: an isochronous endpoint never produces a hit.
  p_iso_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_o & ep_iso_i) == '0));

  // R3: a NAK alone, with reporting off, produces no hit.
  p_nak_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_o & evt_nak_i & ~nak_rep_i & ~evt_tx_ok_i & ~evt_rx_ok_i) == '0));

endmodule

// File: rtl/ep_irq_status.sv
module ep_irq_status #(
  parameter int NUM_EP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] hit_i,
  input  logic [NUM_EP-1:0] clr_mask_i,
  input  logic [NUM_EP-1:0] set_mask_i,
  output logic [NUM_EP-1:0] sts_o
);

  logic [NUM_EP-1:0] sts_q;
  logic [NUM_EP-1:0] sts_d;
  logic [NUM_EP-1:0] collide;
  logic [NUM_EP-1:0] clr_only;

  // Events and the set strobe win over the clear strobe.
  assign sts_d    = (sts_q & ~clr_mask_i) | set_mask_i | hit_i;
  assign collide  = hit_i & clr_mask_i;
  assign clr_only = clr_mask_i & ~hit_i & ~set_mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  // R7: a bit hit by an event and a clear in the same cycle ends up set.
  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (collide != '0) |=> ((sts_q & $past(collide)) == $past(collide)));

  // R5: a bit that is only cleared ends up at 0.
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_only != '0) |=> ((sts_q & $past(clr_only)) == '0));

  // R1: a bit can only rise through an event or the set strobe.
  p_rise_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q) & ~$past(hit_i | set_mask_i)) == '0));

endmodule

// File: rtl/ep_irq_route.sv
module ep_irq_route
  import ep_irq_pkg::*;
#(
  parameter int NUM_EP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] sts_i,
  input  logic [NUM_EP-1:0] en_i,
  input  logic [NUM_EP-1:0] prio_i,
  output logic              irq_fast_o,
  output logic              irq_slow_o
);

  logic req_fast, req_slow;
  logic irq_fast_q, irq_slow_q;

  assign req_fast = line_request(64'(sts_i), 64'(en_i), 64'(prio_i), 1'b1);
  assign req_slow = line_request(64'(sts_i), 64'(en_i), 64'(prio_i), 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_fast_q <= 1'b0;
      irq_slow_q <= 1'b0;
    end else begin
      irq_fast_q <= req_fast;
      irq_slow_q <= req_slow;
    end
  end

  assign irq_fast_o = irq_fast_q;
  assign irq_slow_o = irq_slow_q;

  // R9: the slow line follows the enabled, low-priority status one cycle later.
  p_slow_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (irq_slow_q == |($past(sts_i) & $past(en_i) & ~$past(prio_i))));

  // R10: the fast line follows the enabled, high-priority status one cycle later.
  p_fast_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (irq_fast_q == |($past(sts_i) & $past(en_i) & $past(prio_i))));

  // R11: with nothing enabled, neither line may rise.
  p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> (!$rose(irq_fast_q) && !$rose(irq_slow_q)));

endmodule

// File: rtl/ep_irq_ctrl.sv
module ep_irq_ctrl
  import ep_irq_pkg::*;
#(
  parameter int NUM_LOG_EP = 16,
  localparam int NUM_EP    = 2 * NUM_LOG_EP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [NUM_EP-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [NUM_EP-1:0] rd_data_o,
  input  logic [NUM_EP-1:0] ep_iso_i,
  input  logic [NUM_EP-1:0] evt_rx_ok_i,
  input  logic [NUM_EP-1:0] evt_tx_ok_i,
  input  logic [NUM_EP-1:0] evt_nak_i,
  output logic              irq_fast_o,
  output logic              irq_slow_o
);

  logic [NUM_EP-1:0] sts, en, prio, nak_rep, clr_mask, set_mask, hit;

  ep_irq_regs #(.NUM_EP(NUM_EP)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .sts_i      (sts),
    .rd_data_o  (rd_data_o),
    .en_o       (en),
    .prio_o     (prio),
    .nak_rep_o  (nak_rep),
    .clr_mask_o (clr_mask),
    .set_mask_o (set_mask)
  );

  ep_irq_src #(.NUM_EP(NUM_EP)) u_src (
    .clk         (clk),
    .rst_n       (rst_n),
    .ep_iso_i    (ep_iso_i),
    .evt_rx_ok_i (evt_rx_ok_i),
    .evt_tx_ok_i (evt_tx_ok_i),
    .evt_nak_i   (evt_nak_i),
    .nak_rep_i   (nak_rep),
    .hit_o       (hit)
  );

  ep_irq_status #(.NUM_EP(NUM_EP)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit),
    .clr_mask_i (clr_mask),
    .set_mask_i (set_mask),
    .sts_o      (sts)
  );

  ep_irq_route #(.NUM_EP(NUM_EP)) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .sts_i      (sts),
    .en_i       (en),
    .prio_i     (prio),
    .irq_fast_o (irq_fast_o),
    .irq_slow_o (irq_slow_o)
  );

  // R8: both lines stay low in the first cycle after reset.
  p_reset_quiet_r8: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq_fast_o && !irq_slow_o));

endmodule

// File: tb/ep_irq_ctrl_tb.sv
module ep_irq_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NLOG = 2;
  localparam int N    = 2 * NLOG;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [2:0]   wr_addr_i = '0;
  logic [N-1:0] wr_data_i = '0;
  logic [2:0]   rd_addr_i = '0;
  logic [N-1:0] rd_data_o;
  logic [N-1:0] ep_iso_i = '0;
  logic [N-1:0] evt_rx_ok_i = '0;
  logic [N-1:0] evt_tx_ok_i = '0;
  logic [N-1:0] evt_nak_i = '0;
  logic         irq_fast_o, irq_slow_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_irq_ctrl #(.NUM_LOG_EP(NLOG)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .ep_iso_i(ep_iso_i), .evt_rx_ok_i(evt_rx_ok_i), .evt_tx_ok_i(evt_tx_ok_i),
    .evt_nak_i(evt_nak_i), .irq_fast_o(irq_fast_o), .irq_slow_o(irq_slow_o)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string req);
    rd_addr_i = a;
    #1;
    chk(int'(rd_data_o), exp, req);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] rx, input logic [N-1:0] tx, input logic [N-1:0] nak);
    @(negedge clk);
    evt_rx_ok_i = rx; evt_tx_ok_i = tx; evt_nak_i = nak;
    @(negedge clk);
    evt_rx_ok_i = '0; evt_tx_ok_i = '0; evt_nak_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    string tag;
    int exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset values
    rd_chk(3'd0, 0, "R8 status");
    rd_chk(3'd1, 3, "R8 enable");
    rd_chk(3'd4, 0, "R8 prio");
    rd_chk(3'd5, 0, "R8 nakrep");
    chk(int'(irq_fast_o), 0, "R8 fast");
    chk(int'(irq_slow_o), 0, "R8 slow");
    // R6: write-only and unmapped addresses read 0
    wr(3'd3, '1);
    rd_chk(3'd2, 0, "R6 clear reads 0");
    rd_chk(3'd3, 0, "R6 set reads 0");
    rd_chk(3'd6, 0, "R6 unmapped reads 0");
    rd_chk(3'd7, 0, "R6 unmapped reads 0");

    // R1 R2 R3 R4: event qualification sweep
    for (int p = 0; p < N; p++)
      for (int iso = 0; iso < 2; iso++)
        for (int nr = 0; nr < 2; nr++)
          for (int ev = 0; ev < 8; ev++) begin
            logic rx, tx, nk, isin;
            rx = ev[0]; tx = ev[1]; nk = ev[2];
            isin = (p % 2) == 1;
            wr(3'd2, '1);
            wr(3'd5, nr ? N'(1 << p) : '0);
            ep_iso_i = iso ? N'(1 << p) : '0;
            pulse(rx ? N'(1 << p) : '0, tx ? N'(1 << p) : '0, nk ? N'(1 << p) : '0);
            exp = (iso == 0 && (isin ? (tx || (nk && nr == 1)) : rx)) ? (1 << p) : 0;
            if (iso == 1) tag = "R4 iso event";
            else if (!isin) tag = "R1 out event";
            else if (nk && !tx) tag = "R3 nak event";
            else tag = "R2 in event";
            rd_chk(3'd0, exp, tag);
            ep_iso_i = '0;
          end
    wr(3'd5, '0);

    // R6: set patterns
    for (int s = 0; s < 16; s++) begin
      wr(3'd2, '1);
      wr(3'd3, N'(s));
      rd_chk(3'd0, s, "R6 set");
    end
    // R5: clear patterns
    for (int c = 0; c < 16; c++) begin
      wr(3'd3, '1);
      wr(3'd2, N'(c));
      rd_chk(3'd0, (~c) & 4'hF, "R5 clear");
    end

    // R7: events collide with clear of all bits
    wr(3'd3, '1);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 3'd2; wr_data_i = '1;
    evt_rx_ok_i = 4'b0001; evt_tx_ok_i = 4'b0010;
    @(negedge clk);
    wr_en_i = 1'b0; evt_rx_ok_i = '0; evt_tx_ok_i = '0;
    rd_chk(3'd0, 3, "R7 event beats clear");

    // R11: disabled endpoint sets status but is not routed
    wr(3'd1, 4'b0001);
    wr(3'd4, '0);
    wr(3'd2, '1);
    pulse('0, 4'b1000, '0);
    rd_chk(3'd0, 8, "R11 disabled status set");
    @(negedge clk);
    chk(int'(irq_slow_o), 0, "R11 disabled not routed slow");
    chk(int'(irq_fast_o), 0, "R11 disabled not routed fast");
    wr(3'd1, 4'b1001);
    @(negedge clk);
    chk(int'(irq_slow_o), 1, "R11 routed once enabled");

    // R9 R10 R12: full routing sweep
    for (int e = 0; e < 16; e++)
      for (int pr = 0; pr < 16; pr++) begin
        wr(3'd1, N'(e));
        wr(3'd4, N'(pr));
        rd_chk(3'd1, e, "R12 enable readback");
        rd_chk(3'd4, pr, "R12 prio readback");
        for (int s = 0; s < 16; s++) begin
          wr(3'd2, '1);
          wr(3'd3, N'(s));
          @(negedge clk);
          chk(int'(irq_slow_o), int'((s & e & ~pr & 15) != 0), "R9 slow line");
          chk(int'(irq_fast_o), int'((s & e & pr) != 0), "R10 fast line");
        end
      end
    wr(3'd5, 4'b1010);
    rd_chk(3'd5, 10, "R12 nakrep readback");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule